// File: doc/BRIEF.md
# Resampler Path Selector with Hysteresis

This block sits at the front of a 48 kHz audio processing pipeline. It picks which of three mutually exclusive input sources feeds the pipeline and how the sample rate converter treats that stream. The three sources are a codec link, a three-wire serial (I2S) port and a consumer digital audio (S/PDIF) receiver. For the converter it decides two things: whether an x2 FIR interpolation stage is placed ahead of the anti-alias filter, and whether the converter is bypassed.

A rate measurement loop elsewhere supplies the input rate in Hz and a lock indication. The interpolator decision compares that rate against a programmable threshold. A fixed band of plus and minus `HYST_HALF` Hz around the threshold keeps the decision from toggling when the rate sits near the threshold. A rate outside the supported window raises a flag and leaves the interpolator choice unchanged. Every output is registered and is updated only on clock edges where the lock input is high.

Top module: `src_path_sel`

## Requirements
- R1: After reset the outputs are: source select 3'b001 (I2S), interpolator flag 0, bypass flag 0 and out-of-range flag 0.
- R2: When `codec_strap` is 1, the source select becomes 3'b100 (codec link) whatever the value of `stream_sel`.
- R3: When `codec_strap` is 0, the source select becomes 3'b001 (I2S) if `stream_sel` is 0, and 3'b010 (S/PDIF) if `stream_sel` is 1.
- R4: For an in-range rate, `fir_x2_en` becomes 1 when the rate is below threshold−HYST_HALF, and becomes 0 when the rate is above threshold+HYST_HALF (defaults give a 1 kHz band).
- R5: For an in-range rate between threshold−HYST_HALF and threshold+HYST_HALF, both bounds included, `fir_x2_en` keeps its previous value.
- R6: `src_bypass` becomes 1 only when the I2S source is chosen, `port_master` is 1 and `bypass_req` is 1.
- R7: With the S/PDIF source, the codec source, or I2S with `port_master` at 0, `src_bypass` becomes 0 whatever `bypass_req` says.
- R8: A rate below MIN_RATE (32000) or above MAX_RATE (96000) sets `rate_oor` to 1 and holds `fir_x2_en`. A rate from 32000 to 96000 inclusive sets `rate_oor` to 0.
- R9: While `rate_lock` is 0, all outputs keep their values. Every update takes effect one clock after inputs are sampled with `rate_lock` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| codec_strap | input | 1 | Board strap; 1 selects the codec link |
| stream_sel | input | 1 | 0 = I2S, 1 = S/PDIF (used only when strap is 0) |
| bypass_req | input | 1 | Request to bypass the resampler |
| port_master | input | 1 | 1 when the I2S port runs as clock master at 48 kHz |
| rate_hz | input | RATE_W | Measured input sample rate in Hz |
| thresh_hz | input | RATE_W | Interpolator switching threshold in Hz |
| rate_lock | input | 1 | Rate measurement locked; enables updates |
| src_onehot | output | 3 | One-hot source: bit0 I2S, bit1 S/PDIF, bit2 codec |
| fir_x2_en | output | 1 | Insert the x2 FIR interpolator |
| src_bypass | output | 1 | Bypass the resampler |
| rate_oor | output | 1 | Measured rate outside the supported window |

## Verification
The bench uses the default parameters: RATE_W of 17, a 500 Hz half band, and a 32000 to 96000 Hz window. A 17-bit rate reaches 131071, so rates above the window can be driven as well as rates below it. The random rate is drawn mostly within a few hundred hertz of a changing threshold. This makes the band edges at exactly ±500 Hz, and crossings in both directions, occur often. The bench also holds the lock input low for stretches, so held outputs are checked against changing inputs.

// File: rtl/src_path_pkg.sv
package src_path_pkg;
  localparam int unsigned NUM_SRC = 3;
  typedef enum logic [1:0] {
    SRC_I2S   = 2'd0,
    SRC_SPDIF = 2'd1,
    SRC_CODEC = 2'd2
  } src_id_e;

  function automatic logic [NUM_SRC-1:0] src_to_onehot(input src_id_e id);
    logic [NUM_SRC-1:0] v;
    v = '0;
    v[id] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/src_select_dec.sv
module src_select_dec
  import src_path_pkg::*;
(
  input  logic               codec_strap,
  input  logic               stream_sel,
  input  logic               bypass_req,
  input  logic               port_master,
  output logic [NUM_SRC-1:0] src_next,
  output logic               byp_next
);
  src_id_e id;

  always_comb begin
    if (codec_strap)     id = SRC_CODEC;
    else if (stream_sel) id = SRC_SPDIF;
    else                 id = SRC_I2S;
  end

  always_comb begin
    src_next = src_to_onehot(id);
    byp_next = (id == SRC_I2S) && port_master && bypass_req;
  end
endmodule

// File: rtl/rate_window.sv
module rate_window #(
  parameter int unsigned RATE_W    = 17,
  parameter int unsigned HYST_HALF = 500,
  parameter int unsigned MIN_RATE  = 32000,
  parameter int unsigned MAX_RATE  = 96000
) (
  input  logic [RATE_W-1:0] rate_hz,
  input  logic [RATE_W-1:0] thresh_hz,
  output logic              in_range,
  output logic              go_direct,
  output logic              go_fir
);
  localparam int unsigned EW = RATE_W + 1;
  localparam logic [EW-1:0] HALF_E = EW'(HYST_HALF);
  localparam logic [RATE_W-1:0] LO = RATE_W'(MIN_RATE);
  localparam logic [RATE_W-1:0] HI = RATE_W'(MAX_RATE);

  logic [EW-1:0] rate_e, thr_e, upper_e, rate_up_e;

  always_comb begin
    rate_e    = {1'b0, rate_hz};
    thr_e     = {1'b0, thresh_hz};
    upper_e   = thr_e + HALF_E;
    rate_up_e = rate_e + HALF_E;
    in_range  = (rate_hz >= LO) && (rate_hz <= HI);
    go_direct = rate_e > upper_e;
    go_fir    = rate_up_e < thr_e;
  end
endmodule

// File: rtl/src_path_sel.sv
module src_path_sel
  import src_path_pkg::*;
#(
  parameter int unsigned RATE_W    = 17,
  parameter int unsigned HYST_HALF = 500,
  parameter int unsigned MIN_RATE  = 32000,
  parameter int unsigned MAX_RATE  = 96000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              codec_strap,
  input  logic              stream_sel,
  input  logic              bypass_req,
  input  logic              port_master,
  input  logic [RATE_W-1:0] rate_hz,
  input  logic [RATE_W-1:0] thresh_hz,
  input  logic              rate_lock,
  output logic [2:0]        src_onehot,
  output logic              fir_x2_en,
  output logic              src_bypass,
  output logic              rate_oor
);
  localparam logic [NUM_SRC-1:0] SRC_RST = src_to_onehot(SRC_I2S);

  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  logic srst_n;
  assign srst_n = rst_q2;

  logic [NUM_SRC-1:0] src_d, src_q;
  logic byp_d, byp_q, fir_d, fir_q, oor_d, oor_q;
  logic in_range, go_direct, go_fir;
  logic [NUM_SRC-1:0] src_dec;
  logic byp_dec;

  src_select_dec u_dec (
    .codec_strap (codec_strap),
    .stream_sel  (stream_sel),
    .bypass_req  (bypass_req),
    .port_master (port_master),
    .src_next    (src_dec),
    .byp_next    (byp_dec)
  );

  rate_window #(
    .RATE_W    (RATE_W),
    .HYST_HALF (HYST_HALF),
    .MIN_RATE  (MIN_RATE),
    .MAX_RATE  (MAX_RATE)
  ) u_win (
    .rate_hz   (rate_hz),
    .thresh_hz (thresh_hz),
    .in_range  (in_range),
    .go_direct (go_direct),
    .go_fir    (go_fir)
  );

  // next state
  always_comb begin
    src_d = src_dec;
    byp_d = byp_dec;
    oor_d = !in_range;
    fir_d = fir_q;
    if (in_range) begin
      if (go_fir)         fir_d = 1'b1;
      else if (go_direct) fir_d = 1'b0;
    end
  end

  // registers with clock enable
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      src_q <= SRC_RST;
      byp_q <= 1'b0;
      fir_q <= 1'b0;
      oor_q <= 1'b0;
    end else if (rate_lock) begin
      src_q <= src_d;
      byp_q <= byp_d;
      fir_q <= fir_d;
      oor_q <= oor_d;
    end
  end

  assign src_onehot = src_q;
  assign src_bypass = byp_q;
  assign fir_x2_en  = fir_q;
  assign rate_oor   = oor_q;

  localparam logic [RATE_W:0] HALF_E = (RATE_W+1)'(HYST_HALF);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(src_onehot) == 1);

  p_codec_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (rate_lock && codec_strap) |=> src_onehot[2]);

  p_bypass_i2s_r6: assert property (@(posedge clk) disable iff (!srst_n)
    src_bypass |-> src_onehot[0]);

  p_no_bypass_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (rate_lock && !port_master) |=> !src_bypass);

  p_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !rate_lock |=> ($stable(src_onehot) && $stable(fir_x2_en) &&
                    $stable(src_bypass) && $stable(rate_oor)));

  p_oor_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (rate_lock && !in_range) |=> (rate_oor && $stable(fir_x2_en)));

  p_direct_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (rate_lock && in_range && ({1'b0, rate_hz} > {1'b0, thresh_hz} + HALF_E))
      |=> !fir_x2_en);
endmodule

// File: tb/src_path_sel_tb_top.sv
module src_path_sel_tb_top;
  localparam int unsigned RATE_W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic codec_strap = 1'b0, stream_sel = 1'b0, bypass_req = 1'b0;
  logic port_master = 1'b0, rate_lock = 1'b0;
  logic [RATE_W-1:0] rate_hz = '0, thresh_hz = '0;
  logic [2:0] src_onehot;
  logic fir_x2_en, src_bypass, rate_oor;

  always #5 clk = ~clk;

  src_path_sel dut_i (
    .clk(clk), .rst_n(rst_n), .codec_strap(codec_strap), .stream_sel(stream_sel),
    .bypass_req(bypass_req), .port_master(port_master), .rate_hz(rate_hz),
    .thresh_hz(thresh_hz), .rate_lock(rate_lock), .src_onehot(src_onehot),
    .fir_x2_en(fir_x2_en), .src_bypass(src_bypass), .rate_oor(rate_oor)
  );

  int checks = 0;
  int errors = 0;
  logic [2:0] e_src = 3'b001;
  logic e_fir = 1'b0, e_byp = 1'b0, e_oor = 1'b0;

  function automatic logic [2:0] f_src(input logic strap, input logic sel);
    if (strap) return 3'b100;
    return sel ? 3'b010 : 3'b001;
  endfunction

  function automatic logic f_byp(input logic strap, input logic sel,
                                 input logic mst, input logic req);
    return !strap && !sel && mst && req;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // update model for inputs present at the coming edge
  task automatic model_step();
    int r, t;
    r = int'(rate_hz);
    t = int'(thresh_hz);
    if (rate_lock) begin
      e_src = f_src(codec_strap, stream_sel);
      e_byp = f_byp(codec_strap, stream_sel, port_master, bypass_req);
      e_oor = (r < 32000) || (r > 96000);
      if (!e_oor) begin
        if (r + 500 < t)      e_fir = 1'b1;
        else if (r > t + 500) e_fir = 1'b0;
      end
    end
  endtask

  task automatic cycle_and_check(input string ftag);
    model_step();
    @(posedge clk);
    #1;
    chk(rate_lock ? "R2/R3 src" : "R9 src", int'(src_onehot), int'(e_src));
    chk(ftag, int'(fir_x2_en), int'(e_fir));
    chk(rate_lock ? "R6/R7 bypass" : "R9 bypass", int'(src_bypass), int'(e_byp));
    chk("R8 oor", int'(rate_oor), int'(e_oor));
    @(negedge clk);
  endtask

  task automatic drive(input logic strap, input logic sel, input logic req,
                       input logic mst, input int rate, input int thr,
                       input logic lock);
    codec_strap = strap; stream_sel = sel; bypass_req = req; port_master = mst;
    rate_hz = RATE_W'(rate); thresh_hz = RATE_W'(thr); rate_lock = lock;
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 src", int'(src_onehot), 1);
    chk("R1 fir", int'(fir_x2_en), 0);
    chk("R1 bypass", int'(src_bypass), 0);
    chk("R1 oor", int'(rate_oor), 0);

    // R2 strap overrides select
    drive(1, 1, 1, 1, 48000, 40000, 1); cycle_and_check("R2 fir");
    drive(1, 0, 1, 1, 48000, 40000, 1); cycle_and_check("R2 fir");
    // R3 and R6 master bypass
    drive(0, 0, 1, 1, 48000, 40000, 1); cycle_and_check("R6 fir");
    chk("R6 bypass on", int'(src_bypass), 1);
    drive(0, 1, 1, 1, 48000, 40000, 1); cycle_and_check("R7 fir");
    chk("R7 spdif no bypass", int'(src_bypass), 0);
    drive(0, 0, 1, 0, 48000, 40000, 1); cycle_and_check("R7 fir");
    chk("R7 slave no bypass", int'(src_bypass), 0);
    // R4 below band inserts FIR, R5 exact edges hold
    drive(0, 0, 0, 0, 44000, 44501, 1); cycle_and_check("R4 fir below");
    chk("R4 fir set", int'(fir_x2_en), 1);
    drive(0, 0, 0, 0, 45000, 44500, 1); cycle_and_check("R5 fir upper edge");
    chk("R5 held at +500", int'(fir_x2_en), 1);
    drive(0, 0, 0, 0, 45001, 44500, 1); cycle_and_check("R4 fir above");
    chk("R4 fir cleared", int'(fir_x2_en), 0);
    drive(0, 0, 0, 0, 44000, 44500, 1); cycle_and_check("R5 fir lower edge");
    chk("R5 held at -500", int'(fir_x2_en), 0);
    // R8 out of range holds fir
    drive(0, 0, 0, 0, 31999, 60000, 1); cycle_and_check("R8 fir hold low");
    chk("R8 oor low", int'(rate_oor), 1);
    chk("R8 fir held", int'(fir_x2_en), 0);
    drive(0, 0, 0, 0, 32000, 60000, 1); cycle_and_check("R8 fir at min");
    chk("R8 in range at min", int'(rate_oor), 0);
    drive(0, 0, 0, 0, 96001, 20000, 1); cycle_and_check("R8 fir hold high");
    drive(0, 0, 0, 0, 96000, 20000, 1); cycle_and_check("R8 fir at max");
    // R9 lock low holds everything
    drive(1, 1, 1, 1, 100000, 90000, 0); cycle_and_check("R9 fir");
    chk("R9 src held", int'(src_onehot), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int thr, rate, sel;
      thr  = 36000 + int'($urandom_range(0, 56000));
      sel  = int'($urandom_range(0, 9));
      if (sel < 6)      rate = thr - 700 + int'($urandom_range(0, 1400));
      else if (sel < 8) rate = int'($urandom_range(20000, 110000));
      else              rate = thr + ((sel == 8) ? 500 : -500);
      drive(logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 1)),
            logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
            rate, thr, logic'($urandom_range(0, 4) != 0));
      cycle_and_check(rate_lock ? "R4/R5 fir" : "R9 fir");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule